// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a small in-order processor core for a 32-bit load/store instruction subset: register add, subtract, AND, OR and signed set-less-than, word load, word store, branch-if-equal, and the all-zero no-op. Work flows through five clocked stages: fetch, decode, execute, memory access and register writeback. Each stage register carries the data an instruction still needs together with the control strobes that later stages still consume. A strobe is dropped once the stage that uses it has been passed.

The core drives an instruction address and takes back the instruction word in the same cycle. A second port gives data-memory access with a combinational read and a write strobe that the memory captures on the rising edge. No forwarding, stall or flush logic exists. Software spaces dependent instructions with no-ops, and the three instructions fetched behind a branch always complete. The branch is resolved in the memory stage.

Top module: `pipe5_core`

## Requirements
- R1: While `rstN` is low and on the first rising edge after it goes high, `imemAddr` is 0. All 32 registers read as zero after reset. No data write occurs until the first instruction reaches the memory stage, three rising edges after release.
- R2: When no branch is taken, `imemAddr` advances by 4 on every rising edge.
- R3: With opcode 0 (bits 31:26), sources in bits 25:21 and 20:16, destination in bits 15:11 and function code in bits 5:0, the core writes rs+rt for 0x20, rs-rt for 0x22, rs AND rt for 0x24, rs OR rt for 0x25, and 1 or 0 for 0x2A as a signed rs<rt.
- R4: Opcode 0x23 loads the word at rs plus the sign-extended bits 15:0 into the register in bits 20:16. Opcode 0x2B stores that register to the same kind of address. Negative offsets reach lower addresses.
- R5: Register 0 reads as zero even after an instruction targets it.
- R6: A register written by one instruction is read correctly by an instruction fetched three slots later, that is, with two no-ops between them.
- R7: With zero or one instruction between producer and consumer, the consumer reads the old register value.
- R8: Opcode 0x04 with equal rs and rt is taken. The fetch that follows the beq's memory-stage cycle goes to beq address + 4 + 4 times the sign-extended bits 15:0. The three instructions behind the beq still execute.
- R9: Opcode 0x04 with unequal registers does not change the fetch sequence.
- R10: `dmemWe` is raised only for store instructions, once per store, with that store's address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock; the register file writes on the falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| imemAddr | output | 32 | Fetch address (program counter) |
| imemData | input | 32 | Instruction word at `imemAddr` |
| dmemAddr | output | 32 | Data byte address from the memory stage |
| dmemWrData | output | 32 | Store data |
| dmemWe | output | 1 | Store strobe, captured on the rising edge |
| dmemRdData | input | 32 | Load data at `dmemAddr` |

## Verification
A corrupted fetch register shows up on `imemAddr` at the very next rising edge. That makes sequencing faults and wrong branch targets visible within one cycle of the memory-stage decision. Faults in the decode, ALU or register file stay hidden until a store carries the bad value to the data port. Every program therefore ends by storing its results, and those faults surface about four cycles after the faulty instruction. Gap-sensitive programs contrast a stale read with a correct read, so a timing fault in the falling-edge write path shows up as a wrong stored word.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int XLEN   = 32;
  localparam int RIDX_W = 5;
  localparam int NREGS  = 1 << RIDX_W;
  localparam int OP_W   = 6;
  localparam int IMM_W  = 16;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'h00;
  localparam logic [OP_W-1:0] OP_LW    = 6'h23;
  localparam logic [OP_W-1:0] OP_SW    = 6'h2B;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'h04;

  localparam logic [OP_W-1:0] FN_ADD = 6'h20;
  localparam logic [OP_W-1:0] FN_SUB = 6'h22;
  localparam logic [OP_W-1:0] FN_AND = 6'h24;
  localparam logic [OP_W-1:0] FN_OR  = 6'h25;
  localparam logic [OP_W-1:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } aluCtl_e;

  typedef enum logic [1:0] {
    MAIN_ADD   = 2'b00,
    MAIN_SUB   = 2'b01,
    MAIN_FUNCT = 2'b10
  } aluMain_e;

  typedef struct packed {
    logic    regWrite;
    logic    memToReg;
    logic    memWrite;
    logic    branch;
    aluCtl_e aluCtl;
    logic    aluSrc;
    logic    regDst;
  } ctrl_t;

  typedef struct packed {
    logic [XLEN-1:0] instr;
    logic [XLEN-1:0] pcPlus4;
  } fdReg_t;

  typedef struct packed {
    ctrl_t             ctrl;
    logic [XLEN-1:0]   rd1;
    logic [XLEN-1:0]   rd2;
    logic [XLEN-1:0]   signImm;
    logic [XLEN-1:0]   pcPlus4;
    logic [RIDX_W-1:0] rt;
    logic [RIDX_W-1:0] rd;
  } deReg_t;

  typedef struct packed {
    logic              regWrite;
    logic              memToReg;
    logic              memWrite;
    logic              branch;
    logic              zero;
    logic [XLEN-1:0]   aluOut;
    logic [XLEN-1:0]   writeData;
    logic [XLEN-1:0]   pcBranch;
    logic [RIDX_W-1:0] writeReg;
  } emReg_t;

  typedef struct packed {
    logic              regWrite;
    logic              memToReg;
    logic [XLEN-1:0]   readData;
    logic [XLEN-1:0]   aluOut;
    logic [RIDX_W-1:0] writeReg;
  } mwReg_t;
endpackage

// File: rtl/pipe5_ctrl.sv
module pipe5_ctrl
  import pipe5_pkg::*;
(
  input  logic [OP_W-1:0] opD,
  input  logic [OP_W-1:0] functD,
  input  logic            branchM,
  input  logic            zeroM,
  output ctrl_t           ctrlD,
  output logic            pcSrcM
);
  aluMain_e mainOp;

  // main decoder: opcode to strobes plus a coarse ALU class
  always_comb begin
    ctrlD  = '0;
    mainOp = MAIN_ADD;
    unique case (opD)
      OP_RTYPE: begin
        ctrlD.regWrite = 1'b1;
        ctrlD.regDst   = 1'b1;
        mainOp         = MAIN_FUNCT;
      end
      OP_LW: begin
        ctrlD.regWrite = 1'b1;
        ctrlD.aluSrc   = 1'b1;
        ctrlD.memToReg = 1'b1;
      end
      OP_SW: begin
        ctrlD.aluSrc   = 1'b1;
        ctrlD.memWrite = 1'b1;
      end
      OP_BEQ: begin
        ctrlD.branch = 1'b1;
        mainOp       = MAIN_SUB;
      end
      default: ;
    endcase

    // ALU decoder: class plus function code to the 3-bit operation
    unique case (mainOp)
      MAIN_SUB:   ctrlD.aluCtl = ALU_SUB;
      MAIN_FUNCT: begin
        unique case (functD)
          FN_SUB:  ctrlD.aluCtl = ALU_SUB;
          FN_AND:  ctrlD.aluCtl = ALU_AND;
          FN_OR:   ctrlD.aluCtl = ALU_OR;
          FN_SLT:  ctrlD.aluCtl = ALU_SLT;
          default: ctrlD.aluCtl = ALU_ADD;
        endcase
      end
      default:    ctrlD.aluCtl = ALU_ADD;
    endcase
  end

  // branch decision consumed in the memory stage
  assign pcSrcM = branchM & zeroM;
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] rdAddr1,
  input  logic [ADDR_W-1:0] rdAddr2,
  output logic [DATA_W-1:0] rdData1,
  output logic [DATA_W-1:0] rdData2,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] regs [DEPTH];

  // falling-edge write: decode in the same cycle sees the new value
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (wrEn && (wrAddr != '0)) begin
      regs[wrAddr] <= wrData;
    end
  end

  assign rdData1 = (rdAddr1 == '0) ? '0 : regs[rdAddr1];
  assign rdData2 = (rdAddr2 == '0) ? '0 : regs[rdAddr2];
endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
  import pipe5_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  aluCtl_e      aluCtl,
  output logic [W-1:0] result,
  output logic         zero
);
  always_comb begin
    unique case (aluCtl)
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_SUB: result = opA - opB;
      ALU_SLT: result = {{(W-1){1'b0}}, ($signed(opA) < $signed(opB))};
      default: result = opA + opB;
    endcase
  end

  assign zero = (result == '0);
endmodule

// File: rtl/pipe5_datapath.sv
module pipe5_datapath
  import pipe5_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctrlD,
  input  logic             pcSrcM,
  output logic [OP_W-1:0]  opD,
  output logic [OP_W-1:0]  functD,
  output logic             branchM,
  output logic             zeroM,
  output logic [XLEN-1:0]  imemAddr,
  input  logic [XLEN-1:0]  imemData,
  output logic [XLEN-1:0]  dmemAddr,
  output logic [XLEN-1:0]  dmemWrData,
  output logic             dmemWe,
  input  logic [XLEN-1:0]  dmemRdData
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] pcF, pcPlus4F, pcNext;
  fdReg_t fdQ, fdNext;
  deReg_t deQ, deNext;
  emReg_t emQ, emNext;
  mwReg_t mwQ, mwNext;

  logic [RIDX_W-1:0] rsD, rtD, rdD;
  logic [XLEN-1:0]   rd1D, rd2D, signImmD;
  logic [XLEN-1:0]   srcBE, aluOutE;
  logic              zeroE;
  logic [XLEN-1:0]   resultW;

  // ---------------- fetch ----------------
  assign pcPlus4F = pcF + STEP;
  assign pcNext   = pcSrcM ? emQ.pcBranch : pcPlus4F;
  assign imemAddr = pcF;
  assign fdNext   = '{instr: imemData, pcPlus4: pcPlus4F};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcF <= '0;
      fdQ <= '0;
    end else begin
      pcF <= pcNext;
      fdQ <= fdNext;
    end
  end

  // ---------------- decode ----------------
  assign opD      = fdQ.instr[31:26];
  assign rsD      = fdQ.instr[25:21];
  assign rtD      = fdQ.instr[20:16];
  assign rdD      = fdQ.instr[15:11];
  assign functD   = fdQ.instr[5:0];
  assign signImmD = {{(XLEN-IMM_W){fdQ.instr[IMM_W-1]}}, fdQ.instr[IMM_W-1:0]};

  pipe5_regfile #(.DATA_W(XLEN), .ADDR_W(RIDX_W)) u_rf (
    .clk     (clk),
    .rstN    (rstN),
    .rdAddr1 (rsD),
    .rdAddr2 (rtD),
    .rdData1 (rd1D),
    .rdData2 (rd2D),
    .wrEn    (mwQ.regWrite),
    .wrAddr  (mwQ.writeReg),
    .wrData  (resultW)
  );

  always_comb begin
    deNext.ctrl    = ctrlD;
    deNext.rd1     = rd1D;
    deNext.rd2     = rd2D;
    deNext.signImm = signImmD;
    deNext.pcPlus4 = fdQ.pcPlus4;
    deNext.rt      = rtD;
    deNext.rd      = rdD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) deQ <= '0;
    else       deQ <= deNext;
  end

  // ---------------- execute ----------------
  assign srcBE = deQ.ctrl.aluSrc ? deQ.signImm : deQ.rd2;

  pipe5_alu #(.W(XLEN)) u_alu (
    .opA    (deQ.rd1),
    .opB    (srcBE),
    .aluCtl (deQ.ctrl.aluCtl),
    .result (aluOutE),
    .zero   (zeroE)
  );

  always_comb begin
    emNext.regWrite  = deQ.ctrl.regWrite;
    emNext.memToReg  = deQ.ctrl.memToReg;
    emNext.memWrite  = deQ.ctrl.memWrite;
    emNext.branch    = deQ.ctrl.branch;
    emNext.zero      = zeroE;
    emNext.aluOut    = aluOutE;
    emNext.writeData = deQ.rd2;
    emNext.pcBranch  = {deQ.signImm[XLEN-3:0], 2'b00} + deQ.pcPlus4;
    emNext.writeReg  = deQ.ctrl.regDst ? deQ.rd : deQ.rt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) emQ <= '0;
    else       emQ <= emNext;
  end

  // ---------------- memory ----------------
  assign dmemAddr   = emQ.aluOut;
  assign dmemWrData = emQ.writeData;
  assign dmemWe     = emQ.memWrite;
  assign branchM    = emQ.branch;
  assign zeroM      = emQ.zero;

  always_comb begin
    mwNext.regWrite = emQ.regWrite;
    mwNext.memToReg = emQ.memToReg;
    mwNext.readData = dmemRdData;
    mwNext.aluOut   = emQ.aluOut;
    mwNext.writeReg = emQ.writeReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mwQ <= '0;
    else       mwQ <= mwNext;
  end

  // ---------------- writeback ----------------
  assign resultW = mwQ.memToReg ? mwQ.readData : mwQ.aluOut;
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  output logic [31:0] imemAddr,
  input  logic [31:0] imemData,
  output logic [31:0] dmemAddr,
  output logic [31:0] dmemWrData,
  output logic        dmemWe,
  input  logic [31:0] dmemRdData
);
  ctrl_t           ctrlD;
  logic [OP_W-1:0] opD, functD;
  logic            branchM, zeroM, pcSrcM;

  pipe5_ctrl u_ctrl (
    .opD     (opD),
    .functD  (functD),
    .branchM (branchM),
    .zeroM   (zeroM),
    .ctrlD   (ctrlD),
    .pcSrcM  (pcSrcM)
  );

  pipe5_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlD      (ctrlD),
    .pcSrcM     (pcSrcM),
    .opD        (opD),
    .functD     (functD),
    .branchM    (branchM),
    .zeroM      (zeroM),
    .imemAddr   (imemAddr),
    .imemData   (imemData),
    .dmemAddr   (dmemAddr),
    .dmemWrData (dmemWrData),
    .dmemWe     (dmemWe),
    .dmemRdData (dmemRdData)
  );
endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] imemAddr,
  input logic        dmemWe,
  input logic        pcSrcM
);
  logic [2:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  // R1: fetch begins at address zero
  p_reset_pc_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 3'd0) |-> (imemAddr == 32'd0));

  // R1: bubbles from reset never store
  p_quiet_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst < 3'd3) |-> !dmemWe);

  // R2: sequential fetch
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    !pcSrcM |=> (imemAddr == $past(imemAddr) + 32'd4));

  // R8: no branch can resolve before the first instruction reaches memory stage
  p_no_early_branch_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst < 3'd3) |-> !pcSrcM);
endmodule

bind pipe5_core pipe5_core_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .imemAddr (imemAddr),
  .dmemWe   (dmemWe),
  .pcSrcM   (pcSrcM)
);

// File: tb/pipe5_core_tb.sv
`timescale 1ns/1ps
module pipe5_core_tb;
  localparam int MEMW = 64;
  localparam logic [31:0] SENT = 32'hA5A5A5A5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] imemAddr, imemData, dmemAddr, dmemWrData, dmemRdData;
  logic        dmemWe;

  logic [31:0] imem [MEMW];
  logic [31:0] dmem [MEMW];
  int          storeCount = 0;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 0;

  always #5 clk = ~clk;

  pipe5_core u_dut (
    .clk(clk), .rstN(rstN), .imemAddr(imemAddr), .imemData(imemData),
    .dmemAddr(dmemAddr), .dmemWrData(dmemWrData), .dmemWe(dmemWe),
    .dmemRdData(dmemRdData)
  );

  assign imemData   = (imemAddr < 32'd256) ? imem[imemAddr[7:2]] : 32'd0;
  assign dmemRdData = (dmemAddr < 32'd256) ? dmem[dmemAddr[7:2]] : 32'd0;

  always @(posedge clk) begin
    if (dmemWe) begin
      storeCount <= storeCount + 1;
      if (dmemAddr < 32'd256) dmem[dmemAddr[7:2]] <= dmemWrData;
    end
  end

  function automatic logic [31:0] rType(input logic [5:0] fn, input int rd, rs, rt);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] iType(input logic [5:0] op, input int rt, rs, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] lw(input int rt, off, base); return iType(6'h23, rt, base, off); endfunction
  function automatic logic [31:0] sw(input int rt, off, base); return iType(6'h2B, rt, base, off); endfunction
  function automatic logic [31:0] beq(input int rs, rt, imm); return iType(6'h04, rt, rs, imm); endfunction
  function automatic logic [31:0] add(input int rd, rs, rt); return rType(6'h20, rd, rs, rt); endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clearMems();
    for (int i = 0; i < MEMW; i++) begin
      imem[i] = 32'd0;
      dmem[i] = SENT;
    end
    dmem[0] = 32'd7;
    dmem[1] = 32'd5;
    dmem[2] = 32'hFFFFFFFD;
    dmem[3] = 32'd100;
  endtask

  task automatic startRun();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    storeCount = 0;
    rstN = 1'b1;
  endtask

  // R1, R2: reset state and sequential fetch with a no-op program
  task automatic testReset();
    clearMems();
    dmem[32] = 32'hDEAD0000;
    imem[0] = sw(9, 128, 0);
    rstN = 1'b0;
    @(negedge clk);
    check("R1", "imemAddr in reset", imemAddr, 32'd0);
    check("R1", "dmemWe in reset", {31'd0, dmemWe}, 32'd0);
    startRun();
    check("R1", "imemAddr at release", imemAddr, 32'd0);
    @(negedge clk);
    check("R2", "imemAddr after 1 edge", imemAddr, 32'd4);
    @(negedge clk);
    check("R2", "imemAddr after 2 edges", imemAddr, 32'd8);
    repeat (10) @(negedge clk);
    check("R2", "imemAddr after 12 edges", imemAddr, 32'd48);
    check("R1", "register reset value via store", dmem[32], 32'd0);
    check("R10", "store count no-op program", 32'(storeCount), 32'd1);
  endtask

  // R3, R4, R10: arithmetic, logic, compare, load and store
  task automatic testAluMem();
    clearMems();
    imem[0]  = lw(1, 0, 0);
    imem[1]  = lw(2, 4, 0);
    imem[2]  = lw(3, 8, 0);
    imem[3]  = lw(11, 12, 0);
    imem[6]  = add(4, 1, 2);
    imem[7]  = rType(6'h22, 5, 1, 2);
    imem[8]  = rType(6'h24, 6, 1, 2);
    imem[9]  = rType(6'h25, 7, 1, 2);
    imem[10] = rType(6'h2A, 8, 3, 1);
    imem[11] = rType(6'h2A, 9, 1, 2);
    imem[14] = sw(4, 64, 0);
    imem[15] = sw(5, 68, 0);
    imem[16] = sw(6, 72, 0);
    imem[17] = sw(7, 76, 0);
    imem[18] = sw(8, 80, 0);
    imem[19] = sw(9, 84, 0);
    imem[20] = sw(3, -4, 11);
    imem[21] = sw(11, 88, 0);
    startRun();
    repeat (35) @(negedge clk);
    check("R3", "add 7+5", dmem[16], 32'd12);
    check("R3", "sub 7-5", dmem[17], 32'd2);
    check("R3", "and 7&5", dmem[18], 32'd5);
    check("R3", "or 7|5", dmem[19], 32'd7);
    check("R3", "slt -3<7", dmem[20], 32'd1);
    check("R3", "slt 7<5", dmem[21], 32'd0);
    check("R4", "store with negative offset", dmem[24], 32'hFFFFFFFD);
    check("R4", "loaded word stored back", dmem[22], 32'd100);
    check("R10", "store strobe count", 32'(storeCount), 32'd8);
  endtask

  // R5: register zero stays zero
  task automatic testZeroReg();
    clearMems();
    imem[0]  = lw(1, 0, 0);
    imem[1]  = lw(2, 4, 0);
    imem[4]  = add(0, 1, 2);
    imem[5]  = lw(0, 0, 0);
    imem[8]  = sw(0, 128, 0);
    imem[9]  = add(10, 0, 1);
    imem[12] = sw(10, 132, 0);
    startRun();
    repeat (25) @(negedge clk);
    check("R5", "r0 after writes", dmem[32], 32'd0);
    check("R5", "r0 as operand", dmem[33], 32'd7);
  endtask

  // R6, R7: hazard spacing without forwarding
  task automatic testHazards();
    clearMems();
    imem[0]  = lw(1, 0, 0);
    imem[1]  = lw(2, 4, 0);
    imem[4]  = add(12, 1, 2);
    imem[5]  = sw(12, 136, 0);
    imem[6]  = add(13, 1, 2);
    imem[8]  = sw(13, 140, 0);
    imem[9]  = add(14, 1, 2);
    imem[12] = sw(14, 144, 0);
    imem[13] = add(15, 1, 1);
    imem[15] = add(16, 15, 2);
    imem[18] = sw(16, 148, 0);
    startRun();
    repeat (30) @(negedge clk);
    check("R7", "adjacent consumer stale", dmem[34], 32'd0);
    check("R7", "one-gap consumer stale", dmem[35], 32'd0);
    check("R6", "two-gap consumer fresh", dmem[36], 32'd12);
    check("R7", "one-gap ALU operand stale", dmem[37], 32'd5);
  endtask

  // R8, R9: late branch with three shadow slots
  task automatic testBranch();
    clearMems();
    imem[0]  = lw(1, 0, 0);
    imem[1]  = lw(2, 4, 0);
    imem[4]  = beq(1, 2, 5);
    imem[5]  = add(20, 1, 2);
    imem[8]  = beq(1, 1, 4);
    imem[9]  = add(21, 1, 1);
    imem[12] = add(22, 1, 2);
    imem[13] = add(23, 2, 2);
    imem[16] = sw(20, 160, 0);
    imem[17] = sw(21, 164, 0);
    imem[18] = sw(22, 168, 0);
    imem[19] = sw(23, 172, 0);
    startRun();
    repeat (8) @(negedge clk);
    check("R9", "fetch after untaken beq", imemAddr, 32'd32);
    repeat (3) @(negedge clk);
    check("R8", "fetch in beq memory cycle", imemAddr, 32'd44);
    @(negedge clk);
    check("R8", "fetch redirected to target", imemAddr, 32'd52);
    repeat (20) @(negedge clk);
    check("R9", "fall-through executed", dmem[40], 32'd12);
    check("R8", "shadow slot executed", dmem[41], 32'd14);
    check("R8", "skipped instruction", dmem[42], 32'd0);
    check("R8", "target executed", dmem[43], 32'd10);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    testReset();
    testAluMem();
    testZeroReg();
    testHazards();
    testBranch();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule